// File: doc/BRIEF.md
# Interrupt request capture and masking unit

This unit gathers a group of active-low peripheral request lines and reduces them to one maskable interrupt output for a processor, plus a separate non-maskable pulse output. Every maskable line passes through a two-flop synchronizer. Each line can then be handled in one of two modes. In level mode the line is followed directly. In edge mode a released pulse is held in a sticky status bit, which software clears by writing a 1 to it.

A set mask bit removes a source from the decision to interrupt. A global enable bit in the control register gates every maskable source at once. When several enabled sources are pending, the lowest index wins, and that index is shown beside the pending flag. The non-maskable line bypasses both the mask and the enable. It is accepted only after a falling edge followed by a programmable minimum time low, so short glitches are thrown away.

Software reaches the unit through a simple port. A write takes effect on a clock edge, and the read data is combinational from the address. The register map is:

- address 0 is control, where bit 0 is the global enable;
- address 1 is the mask, where 1 means masked;
- address 2 is the mode, where 1 means edge and 0 means level;
- address 3 is status, read to see pending sources and written with 1s to clear edge bits;
- address 4 is the non-maskable minimum duration.

Top module: `irq_capture_top`

## Requirements
- R1: After reset, irq_o and nmi_o are 0. Reading address 0 returns 0 (enable off), address 1 returns all ones (all masked), and address 2 returns 0 (all level mode).
- R2: In level mode (mode bit 0), status bit i is 1 exactly while irq_ni[i] is held low, after the synchronizer delay, and returns to 0 once the line goes high.
- R3: In edge mode (mode bit 1), status bit i is set on the rising (trailing) edge of a low pulse on irq_ni[i]. The falling edge alone sets nothing.
- R4: An edge captured while the source is masked stays in status and raises irq_o as soon as the mask bit is cleared.
- R5: Several pulses on one edge-mode line before service merge into one status bit, and a single clear removes it.
- R6: Writing 1s to address 3 clears the matching edge-mode status bits. Level-mode status bits are unaffected by such writes.
- R7: A source whose mask bit (address 1) is 1 never raises irq_o.
- R8: When control bit 0 is 0, irq_o stays 0 whatever the sources do.
- R9: When several unmasked sources are pending with enable set, irq_o is 1 and irq_id_o is the lowest pending index.
- R10: A low pulse on nmi_ni produces exactly one one-cycle nmi_o pulse if it stays low for at least NMI_LEN+3 cycles, where NMI_LEN is address 4. A pulse shorter than NMI_LEN cycles produces none.
- R11: nmi_o is independent of the mask register and the global enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_ni | input | N_SRC | Maskable request lines, active low |
| nmi_ni | input | 1 | Non-maskable request line, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | N_SRC | Register write data |
| reg_rdata_o | output | N_SRC | Register read data (combinational) |
| irq_o | output | 1 | Maskable interrupt pending |
| irq_id_o | output | $clog2(N_SRC) | Index of the lowest pending source |
| nmi_o | output | 1 | Qualified non-maskable pulse |

## Verification
The bench builds the unit with N_SRC=4 and CNT_W=4. This keeps every status, mask and mode pattern readable as a small literal, and lets a two-line tie exercise the lowest-index rule. A minimum non-maskable duration of 6 cycles places a 3-cycle glitch clearly below the threshold and a 20-cycle hold clearly above it. Because of this, both the reject and the single-pulse outcomes fall inside short, fixed windows.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CTRL    = 3'd0;
  localparam logic [ADDR_W-1:0] A_MASK    = 3'd1;
  localparam logic [ADDR_W-1:0] A_MODE    = 3'd2;
  localparam logic [ADDR_W-1:0] A_STATUS  = 3'd3;
  localparam logic [ADDR_W-1:0] A_NMI_LEN = 3'd4;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W = 1,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= {W{RST_VAL}};
      s2_q <= {W{RST_VAL}};
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/irq_edge_cap.sv
module irq_edge_cap #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] act_i,
  input  logic [N-1:0] edge_mode_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] status_o
);
  logic [N-1:0] act_q;
  logic [N-1:0] edge_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= '0;
    else         act_q <= act_i;
  end

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic trail;
    assign trail = act_q[i] & ~act_i[i];

    // set wins over a simultaneous clear so no event is lost
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) edge_q[i] <= 1'b0;
      else         edge_q[i] <= (edge_q[i] & ~clr_i[i]) | (trail & edge_mode_i[i]);
    end

    assign status_o[i] = edge_mode_i[i] ? edge_q[i] : act_i[i];

    a_r5_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (edge_q[i] && !clr_i[i]) |=> edge_q[i]);
    a_r3_no_set_in_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!edge_q[i] && !edge_mode_i[i]) |=> !edge_q[i]);
  end
endmodule

// File: rtl/irq_nmi_qual.sv
module irq_nmi_qual #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic [CNT_W-1:0] min_len_i,
  output logic             fire_o
);
  logic             act_q, run_q, fire_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      run_q  <= 1'b0;
      fire_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      act_q  <= act_i;
      fire_q <= 1'b0;
      if (!act_i) begin
        run_q <= 1'b0;
      end else if (!act_q) begin
        run_q <= 1'b1;
        cnt_q <= '0;
      end else if (run_q) begin
        if (cnt_q >= min_len_i) begin
          fire_q <= 1'b1;
          run_q  <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign fire_o = fire_q;

  a_r10_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_q |=> !fire_q);
  a_r10_fire_needs_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_q |-> act_q);
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req_i,
  output logic          valid_o,
  output logic [IW-1:0] id_o
);
  always_comb begin
    id_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) id_o = IW'(i);
    end
  end

  assign valid_o = |req_i;
endmodule

// File: rtl/irq_capture_top.sv
module irq_capture_top
  import irq_pkg::*;
#(
  parameter int N_SRC = 16,
  parameter int CNT_W = 8,
  localparam int IW = $clog2(N_SRC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  irq_ni,
  input  logic              nmi_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [N_SRC-1:0]  reg_wdata_i,
  output logic [N_SRC-1:0]  reg_rdata_o,
  output logic              irq_o,
  output logic [IW-1:0]     irq_id_o,
  output logic              nmi_o
);
  logic             gen_en_q;
  logic [N_SRC-1:0] mask_q, mode_q;
  logic [CNT_W-1:0] nmi_len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gen_en_q  <= 1'b0;
      mask_q    <= '1;
      mode_q    <= '0;
      nmi_len_q <= '0;
    end else if (reg_we_i) begin
      case (reg_addr_i)
        A_CTRL:    gen_en_q  <= reg_wdata_i[0];
        A_MASK:    mask_q    <= reg_wdata_i;
        A_MODE:    mode_q    <= reg_wdata_i;
        A_NMI_LEN: nmi_len_q <= reg_wdata_i[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  logic [N_SRC-1:0] irq_s;
  logic             nmi_s;

  irq_sync #(.W(N_SRC), .RST_VAL(1'b1)) u_sync_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(irq_ni), .q_o(irq_s)
  );
  irq_sync #(.W(1), .RST_VAL(1'b1)) u_sync_nmi (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(nmi_ni), .q_o(nmi_s)
  );

  logic [N_SRC-1:0] clr, status, pending;
  assign clr = (reg_we_i && reg_addr_i == A_STATUS) ? reg_wdata_i : '0;

  irq_edge_cap #(.N(N_SRC)) u_cap (
    .clk_i(clk_i), .rst_ni(rst_ni), .act_i(~irq_s), .edge_mode_i(mode_q),
    .clr_i(clr), .status_o(status)
  );

  assign pending = status & ~mask_q & {N_SRC{gen_en_q}};

  irq_prio_enc #(.N(N_SRC), .IW(IW)) u_prio (
    .req_i(pending), .valid_o(irq_o), .id_o(irq_id_o)
  );

  irq_nmi_qual #(.CNT_W(CNT_W)) u_nmi (
    .clk_i(clk_i), .rst_ni(rst_ni), .act_i(~nmi_s), .min_len_i(nmi_len_q),
    .fire_o(nmi_o)
  );

  always_comb begin
    case (reg_addr_i)
      A_CTRL:    reg_rdata_o = N_SRC'(gen_en_q);
      A_MASK:    reg_rdata_o = mask_q;
      A_MODE:    reg_rdata_o = mode_q;
      A_STATUS:  reg_rdata_o = status;
      A_NMI_LEN: reg_rdata_o = N_SRC'(nmi_len_q);
      default:   reg_rdata_o = '0;
    endcase
  end

  a_r7_masked_never_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !mask_q[irq_id_o]);
  a_r8_global_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gen_en_q |-> !irq_o);
  a_r9_winner_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> status[irq_id_o]);
  a_r9_lowest_index: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((pending & ((N_SRC'(1) << irq_id_o) - N_SRC'(1))) == '0));
endmodule

// File: tb/sim_irq_capture_top.sv
module sim_irq_capture_top;
  localparam int N = 4;
  localparam int CW = 4;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq_n = '1;
  logic          nmi_n = 1'b1;
  logic          we = 1'b0;
  logic [2:0]    addr = '0;
  logic [N-1:0]  wdata = '0;
  logic [N-1:0]  rdata;
  logic          irq;
  logic [IW-1:0] irq_id;
  logic          nmi;

  int n_chk = 0;
  int n_bad = 0;
  int nmi_cnt = 0;
  bit done = 0;

  always #5ns clk = ~clk;

  irq_capture_top #(.N_SRC(N), .CNT_W(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .irq_ni(irq_n), .nmi_ni(nmi_n),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_o(irq), .irq_id_o(irq_id), .nmi_o(nmi)
  );

  always @(negedge clk) if (nmi) nmi_cnt++;

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    addr = a;
    #1ns v = int'(rdata);
  endtask

  task automatic t_reset();
    int v;
    chk("R1 irq", irq, 0);
    chk("R1 nmi", nmi, 0);
    rd(3'd0, v); chk("R1 ctrl", v, 0);
    rd(3'd1, v); chk("R1 mask", v, 4'hF);
    rd(3'd2, v); chk("R1 mode", v, 0);
  endtask

  task automatic t_level();
    int v;
    irq_n[2] = 1'b0; cyc(4);
    chk("R2 irq held", irq, 1);
    chk("R2 id", irq_id, 2);
    rd(3'd3, v); chk("R2 status", v, 4'b0100);
    irq_n[2] = 1'b1; cyc(4);
    chk("R2 irq released", irq, 0);
    rd(3'd3, v); chk("R2 status released", v, 0);
  endtask

  task automatic t_prio();
    irq_n[3] = 1'b0; irq_n[1] = 1'b0; cyc(4);
    chk("R9 irq", irq, 1);
    chk("R9 lowest id", irq_id, 1);
    irq_n[1] = 1'b1; cyc(4);
    chk("R9 next id", irq_id, 3);
    irq_n[3] = 1'b1; cyc(4);
    chk("R9 idle", irq, 0);
  endtask

  task automatic t_edge();
    int v;
    wr(3'd2, 4'b0001);
    irq_n[0] = 1'b0; cyc(5);
    chk("R3 no capture on fall", irq, 0);
    rd(3'd3, v); chk("R3 status on fall", v, 0);
    irq_n[0] = 1'b1; cyc(5);
    chk("R3 irq on rise", irq, 1);
    chk("R3 id", irq_id, 0);
    rd(3'd3, v); chk("R3 status on rise", v, 4'b0001);
  endtask

  task automatic t_clear();
    int v;
    irq_n[2] = 1'b0; cyc(4);
    wr(3'd3, 4'b0101);
    rd(3'd3, v); chk("R6 edge cleared, level kept", v, 4'b0100);
    chk("R6 level still pending id", irq_id, 2);
    irq_n[2] = 1'b1; cyc(4);
    chk("R6 idle", irq, 0);
  endtask

  task automatic t_mask();
    int v;
    wr(3'd1, 4'b0101);
    irq_n[0] = 1'b0; cyc(3); irq_n[0] = 1'b1;
    irq_n[2] = 1'b0; cyc(5);
    chk("R7 masked sources silent", irq, 0);
    rd(3'd3, v); chk("R4 status while masked", v, 4'b0101);
    wr(3'd1, 4'b0100);
    chk("R4 pending after unmask", irq, 1);
    chk("R4 id", irq_id, 0);
    wr(3'd3, 4'b0001);
    chk("R7 level masked", irq, 0);
    wr(3'd1, 4'b0000);
    chk("R7 level unmasked", irq, 1);
    irq_n[2] = 1'b1; cyc(4);
  endtask

  task automatic t_merge();
    int v;
    for (int k = 0; k < 3; k++) begin
      irq_n[0] = 1'b0; cyc(3); irq_n[0] = 1'b1; cyc(3);
    end
    cyc(2);
    rd(3'd3, v); chk("R5 merged status", v, 4'b0001);
    wr(3'd3, 4'b0001); cyc(3);
    rd(3'd3, v); chk("R5 single clear", v, 0);
    chk("R5 irq", irq, 0);
  endtask

  task automatic t_gen();
    irq_n[1] = 1'b0; cyc(4);
    chk("R8 on", irq, 1);
    wr(3'd0, 4'b0000);
    chk("R8 blocked", irq, 0);
    wr(3'd0, 4'b0001);
    chk("R8 restored", irq, 1);
    irq_n[1] = 1'b1; cyc(4);
  endtask

  task automatic t_nmi();
    wr(3'd4, 4'd6);
    nmi_cnt = 0;
    nmi_n = 1'b0; cyc(3); nmi_n = 1'b1; cyc(15);
    chk("R10 glitch rejected", nmi_cnt, 0);
    nmi_cnt = 0;
    nmi_n = 1'b0; cyc(20); nmi_n = 1'b1; cyc(5);
    chk("R10 one pulse", nmi_cnt, 1);
    wr(3'd0, 4'b0000); wr(3'd1, 4'b1111);
    nmi_cnt = 0;
    nmi_n = 1'b0; cyc(20); nmi_n = 1'b1; cyc(5);
    chk("R11 unaffected by mask/enable", nmi_cnt, 1);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    wr(3'd0, 4'b0001);
    wr(3'd1, 4'b0000);
    t_level();
    t_prio();
    t_edge();
    t_clear();
    t_mask();
    t_merge();
    t_gen();
    t_nmi();
    done = 1;
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end
endmodule